// File: doc/BRIEF.md
# Data Access Breakpoint Matcher

This block watches the data accesses of a core. Each access has a linear address, a size of 1, 2 or 4 bytes, and a direction. The block compares every access against a small set of programmable watch slots. Each slot holds a watched address, an enable, a kind code and a span length. An access matches a slot when the bytes it touches overlap the bytes the slot watches, and the slot's kind admits the access direction. When that happens, the slot's event bit is set and stays set until software clears it.

A resume input mutes all matching for the cycle in which it is high. This lets the core step past the access that caused the last event. Configuration goes through a narrow write port. The event vector is always visible on an output, and a write-one-to-clear location on the same port clears it.

Top module: `dbg_bp_matcher`

## Requirements
- R1: After reset the event vector is 0 and every slot is disabled, so no access sets any event bit until a slot is enabled.
- R2: A write to config location i (0..3) loads slot i's watched address. A write to location 4 loads the control word: bits [3:0] are the per-slot enables, slot i's kind is at bits [4+4i+1:4+4i], and slot i's length code is at bits [6+4i+1:6+4i]. A write acts on accesses from the next cycle on, not on an access in the same cycle.
- R3: A read presents access class 2'b10 and a write presents class 2'b11. A slot qualifies only if its kind ANDed with the class is nonzero.
- R4: Size codes on acc_size_i are 00=1, 01=2, 10=4 (11 also 4). A qualified slot hits when the access start is at or below the watched address and start+size is above it.
- R5: Length codes are 00=1, 01=2, 11=4 and 10=8 bytes. A qualified slot also hits when the access start is above the watched address and below the watched address plus its length.
- R6: Address sums are formed in 33 bits, so a span near the top of the address space never wraps onto low addresses.
- R7: While resume_i is high, an access sets no event bit.
- R8: A slot whose enable is 0 never sets its event bit. With all enables 0, no access has any effect.
- R9: Every slot that hits sets its own event bit, several bits may be set by one access, and set bits stay set across later accesses.
- R10: A write to config location 5 clears each event bit whose write-data bit in [3:0] is 1. If a hit occurs in the same cycle, the hit wins for its bit.
- R11: An access is taken when acc_valid_i is high at a clock edge, and its hits are visible on evt_o right after that edge. With acc_valid_i low, the access inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 3 | Config location: 0..3 slot address, 4 control, 5 event clear |
| cfg_wdata_i | input | 32 | Config write data |
| acc_valid_i | input | 1 | Data access strobe |
| acc_addr_i | input | 32 | Linear start address of the access |
| acc_size_i | input | 2 | Access size code |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| resume_i | input | 1 | Suppresses all matching while high |
| evt_o | output | 4 | Sticky per-slot event bits |

## Verification
The bound assertions check these properties on every cycle:
- A muted access, or a cycle with no access, never raises a bit.
- A bit never rises for a disabled slot.
- Bits never fall without a clear write.
- A clear without a concurrent access drops the addressed bits.

Whether a given access should hit is a matter of overlap arithmetic. That can only be shown by the bench's scenarios and its cycle-by-cycle model. The scenarios cover the exact span edges on both sides, the 8-byte length code, the kind/direction filter, wrap at the top of the address space, and the relative order of config writes and accesses.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;
  localparam int ADDR_W = 32;

  typedef logic [1:0] code2_t;

  localparam code2_t CLASS_RD = 2'b10;
  localparam code2_t CLASS_WR = 2'b11;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              en;
    code2_t            kind;
    code2_t            len;
  } slot_cfg_t;

  function automatic logic [3:0] len_bytes(input code2_t c);
    case (c)
      2'b00:   return 4'd1;
      2'b01:   return 4'd2;
      2'b10:   return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [2:0] size_bytes(input code2_t c);
    case (c)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dbg_bp_cfg_regs.sv
module dbg_bp_cfg_regs
  import dbg_bp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CFG_AW    = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [CFG_AW-1:0]              addr_i,
  input  logic [ADDR_W-1:0]              wdata_i,
  output slot_cfg_t [NUM_SLOTS-1:0]      slots_o,
  output logic [NUM_SLOTS-1:0]           clr_o
);
  localparam int CTRL_IDX = NUM_SLOTS;
  localparam int CLR_IDX  = NUM_SLOTS + 1;

  logic ctrl_wr;
  assign ctrl_wr = we_i && (addr_i == CFG_AW'(CTRL_IDX));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam int KIND_LSB = NUM_SLOTS + 4 * i;
    localparam int LEN_LSB  = KIND_LSB + 2;
    slot_cfg_t slot_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else begin
        if (we_i && (addr_i == CFG_AW'(i))) slot_q.addr <= wdata_i;
        if (ctrl_wr) begin
          slot_q.en   <= wdata_i[i];
          slot_q.kind <= wdata_i[KIND_LSB +: 2];
          slot_q.len  <= wdata_i[LEN_LSB +: 2];
        end
      end
    end

    assign slots_o[i] = slot_q;
  end

  assign clr_o = (we_i && (addr_i == CFG_AW'(CLR_IDX))) ? wdata_i[NUM_SLOTS-1:0] : '0;
endmodule

// File: rtl/dbg_bp_span_cmp.sv
module dbg_bp_span_cmp
  import dbg_bp_pkg::*;
(
  input  slot_cfg_t         cfg_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  code2_t            size_i,
  input  logic              write_i,
  output logic              hit_o
);
  logic [ADDR_W:0] acc_lo, acc_hi, bp_lo, bp_hi;
  code2_t          acc_class;
  logic            kind_ok, hit_below, hit_above;

  // 33-bit sums keep top-of-memory spans from wrapping
  always_comb begin
    acc_lo    = {1'b0, addr_i};
    acc_hi    = acc_lo + (ADDR_W+1)'(size_bytes(size_i));
    bp_lo     = {1'b0, cfg_i.addr};
    bp_hi     = bp_lo + (ADDR_W+1)'(len_bytes(cfg_i.len));
    acc_class = write_i ? CLASS_WR : CLASS_RD;
    kind_ok   = |(cfg_i.kind & acc_class);
    hit_below = (acc_lo <= bp_lo) && (acc_hi > bp_lo);
    hit_above = (acc_lo > bp_lo) && (acc_lo < bp_hi);
    hit_o     = valid_i && cfg_i.en && kind_ok && (hit_below || hit_above);
  end
endmodule

// File: rtl/dbg_bp_evt_reg.sv
module dbg_bp_evt_reg #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] hit_i,
  input  logic [NUM_SLOTS-1:0] clr_i,
  output logic [NUM_SLOTS-1:0] evt_o
);
  logic [NUM_SLOTS-1:0] evt_q;

  // set wins over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (evt_q & ~clr_i) | hit_i;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/dbg_bp_matcher.sv
module dbg_bp_matcher
  import dbg_bp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CFG_AW    = $clog2(NUM_SLOTS + 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [ADDR_W-1:0]    cfg_wdata_i,
  input  logic                 acc_valid_i,
  input  logic [ADDR_W-1:0]    acc_addr_i,
  input  logic [1:0]           acc_size_i,
  input  logic                 acc_write_i,
  input  logic                 resume_i,
  output logic [NUM_SLOTS-1:0] evt_o
);
  slot_cfg_t [NUM_SLOTS-1:0] slots;
  logic [NUM_SLOTS-1:0]      slot_en, hits, clr;
  logic                      acc_live;

  assign acc_live = acc_valid_i && !resume_i;

  dbg_bp_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .CFG_AW(CFG_AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .slots_o (slots),
    .clr_o   (clr)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign slot_en[i] = slots[i].en;
    dbg_bp_span_cmp u_cmp (
      .cfg_i   (slots[i]),
      .valid_i (acc_live),
      .addr_i  (acc_addr_i),
      .size_i  (acc_size_i),
      .write_i (acc_write_i),
      .hit_o   (hits[i])
    );
  end

  dbg_bp_evt_reg #(.NUM_SLOTS(NUM_SLOTS)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hits),
    .clr_i  (clr),
    .evt_o  (evt_o)
  );
endmodule

// File: rtl/dbg_bp_matcher_chk.sv
module dbg_bp_matcher_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int CFG_AW    = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_we_i,
  input logic [CFG_AW-1:0]    cfg_addr_i,
  input logic [31:0]          cfg_wdata_i,
  input logic                 acc_valid_i,
  input logic                 resume_i,
  input logic [NUM_SLOTS-1:0] en_mask_i,
  input logic [NUM_SLOTS-1:0] evt_o
);
  logic clr_now;
  assign clr_now = cfg_we_i && (cfg_addr_i == CFG_AW'(NUM_SLOTS + 1));

  AST_RESUME_MUTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && resume_i) |=> ((evt_o & ~$past(evt_o)) == '0)); // R7

  AST_IDLE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> ((evt_o & ~$past(evt_o)) == '0)); // R11

  AST_DISABLED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> ((evt_o & ~$past(evt_o) & ~$past(en_mask_i)) == '0)); // R8

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_now |=> ((evt_o & $past(evt_o)) == $past(evt_o))); // R9

  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_now && !acc_valid_i) |=> ((evt_o & $past(cfg_wdata_i[NUM_SLOTS-1:0])) == '0)); // R10
endmodule

bind dbg_bp_matcher dbg_bp_matcher_chk #(.NUM_SLOTS(NUM_SLOTS), .CFG_AW(CFG_AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .acc_valid_i (acc_valid_i),
  .resume_i    (resume_i),
  .en_mask_i   (slot_en),
  .evt_o       (evt_o)
);

// File: tb/sim_dbg_bp_matcher.sv
`timescale 1ns/1ps
module sim_dbg_bp_matcher;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we = 1'b0, acc_valid = 1'b0, acc_write = 1'b0, resume = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [3:0]  evt;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_NS/2) clk = ~clk;

  dbg_bp_matcher u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .acc_valid_i(acc_valid), .acc_addr_i(acc_addr),
    .acc_size_i(acc_size), .acc_write_i(acc_write), .resume_i(resume), .evt_o(evt)
  );

  // behavioural reference
  logic [31:0] m_addr [4];
  logic [1:0]  m_kind [4];
  logic [1:0]  m_len  [4];
  logic [3:0]  m_en, m_evt;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en <= '0; m_evt <= '0;
      for (int i = 0; i < 4; i++) begin m_addr[i] <= '0; m_kind[i] <= '0; m_len[i] <= '0; end
    end else begin
      logic [3:0] nxt;
      nxt = m_evt;
      if (cfg_we && cfg_addr == 3'd5) nxt = nxt & ~cfg_wdata[3:0];
      if (acc_valid && !resume) begin
        for (int i = 0; i < 4; i++) begin
          longint unsigned a, b, sz, ln;
          int cls;
          a  = acc_addr; b = m_addr[i];
          sz = (acc_size == 2'd0) ? 1 : (acc_size == 2'd1) ? 2 : 4;
          ln = (m_len[i] == 2'd0) ? 1 : (m_len[i] == 2'd1) ? 2 : (m_len[i] == 2'd2) ? 8 : 4;
          cls = acc_write ? 3 : 2;
          if (m_en[i] && ((m_kind[i] & cls) != 0) &&
              ((a <= b && a + sz > b) || (a > b && a < b + ln)))
            nxt[i] = 1'b1;
        end
      end
      m_evt <= nxt;
      if (cfg_we && cfg_addr < 3'd4) m_addr[cfg_addr[1:0]] <= cfg_wdata;
      if (cfg_we && cfg_addr == 3'd4) begin
        m_en <= cfg_wdata[3:0];
        for (int i = 0; i < 4; i++) begin
          m_kind[i] <= cfg_wdata[4+4*i +: 2];
          m_len[i]  <= cfg_wdata[6+4*i +: 2];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      n_cmp++;
      if (evt !== m_evt) begin
        n_bad++;
        $display("FAIL %s model: evt_o=%b expected=%b", cur_req, evt, m_evt);
      end
    end
  end

  task automatic check(input logic [3:0] exp, input string req);
    n_cmp++;
    if (evt !== exp) begin
      n_bad++;
      $display("FAIL %s: evt_o=%b expected=%b", req, evt, exp);
    end
  endtask

  logic [3:0] b_en = '0;
  logic [1:0] b_kind [4] = '{default: 2'b00};
  logic [1:0] b_len  [4] = '{default: 2'b00};

  function automatic logic [31:0] mk_ctrl();
    logic [31:0] d = '0;
    d[3:0] = b_en;
    for (int i = 0; i < 4; i++) begin
      d[4+4*i +: 2] = b_kind[i];
      d[6+4*i +: 2] = b_len[i];
    end
    return d;
  endfunction

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic w, input logic r);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = w; resume = r;
    @(negedge clk);
    acc_valid = 1'b0; resume = 1'b0;
  endtask

  task automatic both(input logic [2:0] ca, input logic [31:0] d,
                      input logic [31:0] a, input logic [1:0] sz, input logic w);
    cfg_we = 1'b1; cfg_addr = ca; cfg_wdata = d;
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = w;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
  endtask

  task automatic set_slot(input int i, input logic [31:0] a, input logic [1:0] k,
                          input logic [1:0] l, input logic [3:0] en);
    cfg_wr(3'(i), a);
    b_kind[i] = k; b_len[i] = l; b_en = en;
    cfg_wr(3'd4, mk_ctrl());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(4'b0000, "R1 reset");
    acc(32'h0, 2'd0, 1'b0, 1'b0);
    check(4'b0000, "R1 disabled after reset");

    cur_req = "R5";
    set_slot(0, 32'h1000, 2'b11, 2'b11, 4'b0001);
    acc(32'h1002, 2'd0, 1'b0, 1'b0); check(4'b0001, "R5 inside span");
    cfg_wr(3'd5, 32'h1); check(4'b0000, "R10 clear");
    acc(32'h1004, 2'd0, 1'b0, 1'b0); check(4'b0000, "R5 just past span");

    cur_req = "R4";
    acc(32'h0FFE, 2'd1, 1'b0, 1'b0); check(4'b0000, "R4 end touches address");
    acc(32'h0FFF, 2'd1, 1'b0, 1'b0); check(4'b0001, "R4 covers address");
    cfg_wr(3'd5, 32'hF);

    cur_req = "R3";
    set_slot(1, 32'h2000, 2'b01, 2'b00, 4'b0011);
    acc(32'h2000, 2'd0, 1'b0, 1'b0); check(4'b0000, "R3 read vs write-only kind");
    acc(32'h2000, 2'd0, 1'b1, 1'b0); check(4'b0010, "R3 write vs write-only kind");
    cfg_wr(3'd5, 32'h2);

    cur_req = "R5";
    set_slot(2, 32'h3000, 2'b10, 2'b10, 4'b0111);
    acc(32'h3007, 2'd0, 1'b0, 1'b0); check(4'b0100, "R5 length code 10 = 8 bytes");
    cfg_wr(3'd5, 32'h4);
    acc(32'h3008, 2'd0, 1'b0, 1'b0); check(4'b0000, "R5 beyond 8-byte span");
    acc(32'h3007, 2'd0, 1'b1, 1'b0); check(4'b0100, "R3 write vs kind 10");
    cfg_wr(3'd5, 32'h4);

    cur_req = "R9";
    set_slot(3, 32'h1001, 2'b10, 2'b00, 4'b1111);
    acc(32'h1000, 2'd2, 1'b0, 1'b0); check(4'b1001, "R9 two slots on one access");
    acc(32'h3000, 2'd0, 1'b0, 1'b0); check(4'b1101, "R9 sticky plus new");
    cfg_wr(3'd5, 32'hF); check(4'b0000, "R10 clear all");

    cur_req = "R7";
    acc(32'h1000, 2'd2, 1'b0, 1'b1); check(4'b0000, "R7 resume mutes");

    cur_req = "R8";
    b_en = 4'b0000; cfg_wr(3'd4, mk_ctrl());
    acc(32'h1000, 2'd2, 1'b1, 1'b0); check(4'b0000, "R8 all disabled");
    b_en = 4'b1111; cfg_wr(3'd4, mk_ctrl());

    cur_req = "R6";
    set_slot(0, 32'h0, 2'b11, 2'b00, 4'b1111);
    acc(32'hFFFF_FFFE, 2'd2, 1'b0, 1'b0); check(4'b0000, "R6 no wrap onto address 0");
    set_slot(1, 32'hFFFF_FFFF, 2'b11, 2'b10, 4'b1111);
    acc(32'h0, 2'd2, 1'b1, 1'b0); check(4'b0001, "R6 8-byte span at top does not wrap");
    cfg_wr(3'd5, 32'hF);
    acc(32'hFFFF_FFFE, 2'd2, 1'b0, 1'b0); check(4'b0010, "R6 top-end overlap");
    cfg_wr(3'd5, 32'hF);

    cur_req = "R10";
    acc(32'h1001, 2'd0, 1'b0, 1'b0); check(4'b1000, "R10 setup");
    both(3'd5, 32'h8, 32'h1001, 2'd0, 1'b0); check(4'b1000, "R10 hit wins over clear");
    cfg_wr(3'd5, 32'h8); check(4'b0000, "R10 clear after");

    cur_req = "R11";
    acc_addr = 32'h1001; acc_size = 2'd0; acc_write = 1'b0;
    @(negedge clk); check(4'b0000, "R11 no strobe no effect");

    cur_req = "R2";
    cfg_wr(3'd0, 32'h5000);
    acc(32'h5000, 2'd0, 1'b0, 1'b0); check(4'b0001, "R2 address write used next cycle");
    cfg_wr(3'd5, 32'hF);
    both(3'd0, 32'h6000, 32'h6000, 2'd0, 1'b0); check(4'b0000, "R2 same-cycle write not used");
    acc(32'h6000, 2'd0, 1'b0, 1'b0); check(4'b0001, "R2 new address active");
    cfg_wr(3'd5, 32'hF);

    cur_req = "R9 random";
    for (int n = 0; n < 3000; n++) begin
      int pick;
      logic [31:0] base;
      pick = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: base = 32'h1000;
        1: base = 32'h3000;
        2: base = 32'hFFFF_FFF8;
        default: base = 32'h0;
      endcase
      if (pick == 0) begin
        cfg_wr(3'($urandom_range(0, 3)), base + 32'($urandom_range(0, 7)));
      end else if (pick == 1) begin
        cfg_wr(3'd4, $urandom);
      end else if (pick == 2) begin
        cfg_wr(3'd5, 32'($urandom_range(0, 15)));
      end else begin
        acc_valid = ($urandom_range(0, 4) != 0);
        acc_addr  = base + 32'($urandom_range(0, 11)) - 32'd2;
        acc_size  = 2'($urandom_range(0, 3));
        acc_write = 1'($urandom_range(0, 1));
        resume    = ($urandom_range(0, 7) == 0);
        cfg_we    = ($urandom_range(0, 5) == 0);
        cfg_addr  = 3'd5;
        cfg_wdata = 32'($urandom_range(0, 15));
        @(negedge clk);
        acc_valid = 1'b0; resume = 1'b0; cfg_we = 1'b0;
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run incomplete, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule